// File: doc/BRIEF.md
# Iterative Divider with Single-Cycle Multiply into HI/LO

This block computes 32-bit integer divisions and multiplications and leaves the results in a pair of result registers, HI and LO. A divide places the quotient in LO and the remainder in HI. A multiply places the 64-bit product across HI:LO. A sign-mode input picks between two's-complement and unsigned interpretation of the two operands. Operations are launched with a one-cycle start pulse. Completion is marked by a one-cycle done pulse.

An ordinary divide runs a radix-2 restoring loop on operand magnitudes for 32 iterations, with busy high throughout. The signs of the quotient and remainder are fixed up in the last iteration. Division by zero and the one signed overflow case do not trap and have no undefined result. They are detected at launch and produce fixed values in a single cycle. A multiply also finishes in a single cycle. HI and LO change only in the cycle that an operation completes.

Top module: `hilo_divmul`

## Requirements
- R1: While rst_n is low and after it is released, hi_o and lo_o are zero and busy_o and done_o are low until the first operation.
- R2: An unsigned divide (op_i=0, sign_i=0) with a non-zero divisor raises busy_o for 32 cycles. done_o pulses on the 32nd clock edge after the start edge. It leaves the quotient in lo_o and the remainder in hi_o.
- R3: A signed divide (op_i=0, sign_i=1) that is not a corner case leaves the quotient truncated toward zero in lo_o. It leaves in hi_o a remainder that carries the dividend's sign, with the same 32-cycle timing as R2.
- R4: A signed divide by zero with a negative dividend gives lo_o = 0x00000001 and hi_o = the dividend.
- R5: A signed divide by zero with a non-negative dividend gives lo_o = 0xFFFFFFFF and hi_o = the dividend.
- R6: An unsigned divide by zero gives lo_o = 0xFFFFFFFF and hi_o = the dividend.
- R7: The signed divide of 0x80000000 by 0xFFFFFFFF gives lo_o = 0x80000000 and hi_o = 0.
- R8: The corner cases of R4 to R7 complete on the start edge itself: done_o is high in the following cycle and busy_o never rises.
- R9: A multiply (op_i=1) completes on the start edge. hi_o receives the upper and lo_o the lower 32 bits of the 64-bit product. The operands are sign-extended when sign_i=1 and zero-extended when sign_i=0.
- R10: A start pulse that arrives while busy_o is high has no effect on the operation in progress or on its result.
- R11: done_o is high for exactly one cycle per completed operation, never together with busy_o. hi_o and lo_o hold their values in every cycle in which done_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch pulse, sampled when busy_o is low |
| op_i | input | 1 | 0 = divide, 1 = multiply |
| sign_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_i | input | 32 | Dividend or multiplicand |
| b_i | input | 32 | Divisor or multiplier |
| busy_o | output | 1 | High while a divide iterates |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Remainder or upper product half |
| lo_o | output | 32 | Quotient or lower product half |

## Verification
A wrong iteration count or a lost step shows up as done_o arriving early or late, which is caught in that very cycle. A wrong partial remainder becomes visible only when done_o rises and HI/LO are loaded, at most 32 cycles after the fault. A misrouted sign or a missed corner-case detect shows as a wrong HI or LO value one cycle after the start edge, or after the 32-cycle run. A spurious update of HI or LO between operations is flagged in the cycle it occurs, because the outputs are compared against the model on every clock.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    // operation select carried on op_i
    typedef enum logic {
        OP_DIV = 1'b0,
        OP_MUL = 1'b1
    } hilo_op_e;
endpackage

// File: rtl/hilo_corner.sv
// Detects the divide inputs whose result is fixed rather than iterated.
module hilo_corner #(
    parameter int W = 32
) (
    input  logic         sign_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         hit_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic zero_div;
    logic ovf;

    always_comb begin
        zero_div = (b_i == '0);
        ovf      = sign_i && (a_i == MOST_NEG) && (b_i == ALL_ONES);
        hit_o    = zero_div || ovf;
        hi_o     = '0;
        lo_o     = '0;
        if (zero_div) begin
            hi_o = a_i;
            lo_o = (sign_i && a_i[W-1]) ? ONE : ALL_ONES;
        end else if (ovf) begin
            hi_o = '0;
            lo_o = MOST_NEG;
        end
    end
endmodule

// File: rtl/hilo_divstep.sv
// One restoring iteration: shift one dividend bit into the partial remainder.
module hilo_divstep #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        trial   = shifted - {1'b0, den_i};
        fits    = ~trial[W];
        rem_o   = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/hilo_mul.sv
// Full-width product with sign or zero extension of both operands.
module hilo_mul #(
    parameter int W = 32
) (
    input  logic           sign_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    logic signed [W:0]     a_ext;
    logic signed [W:0]     b_ext;
    logic signed [2*W+1:0] full;

    always_comb begin
        a_ext  = {sign_i & a_i[W-1], a_i};
        b_ext  = {sign_i & b_i[W-1], b_i};
        full   = a_ext * b_ext;
        prod_o = full[2*W-1:0];
    end
endmodule

// File: rtl/hilo_divmul.sv
module hilo_divmul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_i,
    input  logic         sign_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    import hilo_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic          neg_q;
        logic          neg_r;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } state_t;

    state_t s_d, s_q;

    logic           corner_hit;
    logic [W-1:0]   corner_hi, corner_lo;
    logic [W-1:0]   step_rem, step_quo;
    logic [2*W-1:0] prod;
    logic [W-1:0]   a_mag, b_mag;

    hilo_corner #(.W(W)) u_corner (
        .sign_i (sign_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .hit_o  (corner_hit),
        .hi_o   (corner_hi),
        .lo_o   (corner_lo)
    );

    hilo_divstep #(.W(W)) u_step (
        .rem_i (s_q.rem),
        .quo_i (s_q.quo),
        .den_i (s_q.den),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    hilo_mul #(.W(W)) u_mul (
        .sign_i (sign_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    always_comb begin
        a_mag = (sign_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
        b_mag = (sign_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;

        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.rem = step_rem;
            s_d.quo = step_quo;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
                s_d.lo   = s_q.neg_q ? (~step_quo + 1'b1) : step_quo;
                s_d.hi   = s_q.neg_r ? (~step_rem + 1'b1) : step_rem;
            end
        end else if (start_i) begin
            if (hilo_op_e'(op_i) == OP_MUL) begin
                s_d.hi   = prod[2*W-1:W];
                s_d.lo   = prod[W-1:0];
                s_d.done = 1'b1;
            end else if (corner_hit) begin
                s_d.hi   = corner_hi;
                s_d.lo   = corner_lo;
                s_d.done = 1'b1;
            end else begin
                s_d.busy  = 1'b1;
                s_d.cnt   = '0;
                s_d.rem   = '0;
                s_d.quo   = a_mag;
                s_d.den   = b_mag;
                s_d.neg_q = sign_i && (a_i[W-1] ^ b_i[W-1]);
                s_d.neg_r = sign_i && a_i[W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign hi_o   = s_q.hi;
    assign lo_o   = s_q.lo;
endmodule

// File: rtl/hilo_divmul_chk.sv
module hilo_divmul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy_o) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R2: a divide never stays busy longer than its iteration count
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r2_busy_window: assert (busy_run <= W)
                else $error("busy held beyond %0d cycles", W);
        end
    end

    // R11: done never overlaps busy
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R11: HI/LO only move on completion
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

    // R9: multiply completes on the start edge
    a_r9_mul_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i) |=> (done_o && !busy_o));

    // R6: divide by zero copies the dividend into HI in one cycle
    a_r6_zero_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !op_i && (b_i == '0)) |=> (done_o && hi_o == $past(a_i)));

    // R2: the end of an iterative run is always a completion
    a_r2_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

bind hilo_divmul hilo_divmul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/hilo_divmul_bench.sv
module hilo_divmul_bench;
    localparam int W = 32;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         op_i = 1'b0;
    logic         sign_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state
    bit           exp_busy = 1'b0;
    bit           exp_done = 1'b0;
    int           exp_cnt = 0;
    logic [W-1:0] exp_hi = '0, exp_lo = '0;
    logic [W-1:0] pend_hi = '0, pend_lo = '0;
    string        exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    hilo_divmul #(.W(W)) u_hilo_divmul (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sign_i(sign_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    function automatic void ref_result(input bit op, input bit sg, input logic [31:0] a,
                                       input logic [31:0] b, output bit one_cycle,
                                       output logic [31:0] hi, output logic [31:0] lo);
        logic [63:0] p;
        longint sa, sb, q, r;
        longint unsigned ua, ub;
        one_cycle = 1'b1;
        if (op) begin
            if (sg) p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
            else    p = {32'b0, a} * {32'b0, b};
            hi = p[63:32];
            lo = p[31:0];
        end else if (b == 0) begin
            hi = a;
            lo = (sg && a[31]) ? 32'h1 : 32'hFFFF_FFFF;
        end else if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            hi = 32'h0;
            lo = 32'h8000_0000;
        end else begin
            one_cycle = 1'b0;
            if (sg) begin
                sa = longint'($signed(a));
                sb = longint'($signed(b));
                q = sa / sb;
                r = sa % sb;
                lo = q[31:0];
                hi = r[31:0];
            end else begin
                ua = {32'b0, a};
                ub = {32'b0, b};
                lo = 32'(ua / ub);
                hi = 32'(ua % ub);
            end
        end
    endfunction

    always @(posedge clk) begin
        bit oc;
        logic [31:0] h, l;
        if (!rst_n) begin
            exp_busy = 0; exp_done = 0; exp_cnt = 0; exp_hi = '0; exp_lo = '0;
        end else begin
            exp_done = 0;
            if (exp_busy) begin
                exp_cnt++;
                if (exp_cnt == W) begin
                    exp_busy = 0;
                    exp_done = 1;
                    exp_hi = pend_hi;
                    exp_lo = pend_lo;
                end
            end else if (start_i) begin
                ref_result(op_i, sign_i, a_i, b_i, oc, h, l);
                if (oc) begin
                    exp_hi = h; exp_lo = l; exp_done = 1;
                end else begin
                    exp_busy = 1; exp_cnt = 0; pend_hi = h; pend_lo = l;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (busy_o !== exp_busy || done_o !== exp_done || hi_o !== exp_hi || lo_o !== exp_lo) begin
                fails++;
                $display("FAIL %s: busy/done/hi/lo = %0b/%0b/%h/%h expected %0b/%0b/%h/%h",
                         exp_tag, busy_o, done_o, hi_o, lo_o, exp_busy, exp_done, exp_hi, exp_lo);
            end
        end
    end

    task automatic run_op(input string tag, input bit op, input bit sg,
                          input logic [31:0] a, input logic [31:0] b);
        exp_tag = tag;
        @(negedge clk);
        start_i = 1'b1; op_i = op; sign_i = sg; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1", hi_o, 32'h0);
        check_val("R1", lo_o, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: unsigned divides
        run_op("R2", 1'b0, 1'b0, 32'd100, 32'd7);
        check_val("R2", lo_o, 32'd14);
        check_val("R2", hi_o, 32'd2);
        run_op("R2", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd3);
        run_op("R2", 1'b0, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R2", 1'b0, 1'b0, 32'd5, 32'd9);

        // R3: signed divides in all sign combinations
        run_op("R3", 1'b0, 1'b1, -32'sd100, 32'sd7);
        check_val("R3", lo_o, -32'sd14);
        check_val("R3", hi_o, -32'sd2);
        run_op("R3", 1'b0, 1'b1, 32'sd100, -32'sd7);
        run_op("R3", 1'b0, 1'b1, -32'sd100, -32'sd7);
        run_op("R3", 1'b0, 1'b1, 32'h8000_0000, 32'd2);

        // R4, R5, R6, R7, R8: fixed results in one cycle
        run_op("R4", 1'b0, 1'b1, -32'sd5, 32'd0);
        check_val("R4", lo_o, 32'h1);
        run_op("R5", 1'b0, 1'b1, 32'd77, 32'd0);
        check_val("R5", lo_o, 32'hFFFF_FFFF);
        run_op("R5", 1'b0, 1'b1, 32'd0, 32'd0);
        run_op("R6", 1'b0, 1'b0, 32'h9000_0001, 32'd0);
        check_val("R6", hi_o, 32'h9000_0001);
        run_op("R7", 1'b0, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
        check_val("R7", lo_o, 32'h8000_0000);
        check_val("R7", hi_o, 32'h0);
        run_op("R8", 1'b0, 1'b0, 32'd0, 32'd0);

        // R9: multiplies
        run_op("R9", 1'b1, 1'b1, -32'sd3, 32'd5);
        check_val("R9", hi_o, 32'hFFFF_FFFF);
        run_op("R9", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_val("R9", hi_o, 32'hFFFF_FFFE);
        run_op("R9", 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000);

        // R10: start during a divide is ignored
        exp_tag = "R10";
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b0; sign_i = 1'b0; a_i = 32'd1000; b_i = 32'd10;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1; op_i = 1'b1; a_i = 32'd7; b_i = 32'd0;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_busy) @(negedge clk);
        @(negedge clk);
        check_val("R10", lo_o, 32'd100);
        check_val("R10", hi_o, 32'd0);

        // R11: hold between operations
        exp_tag = "R11";
        repeat (6) @(negedge clk);
        check_val("R11", lo_o, 32'd100);

        // mixed operations
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] x, y;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            y = (i % 3 == 0) ? (lfsr >> (i % 28)) : lfsr;
            run_op((i % 4 == 3) ? "R9" : ((i % 2) ? "R3" : "R2"), (i % 4 == 3), i[0], x, y);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule